// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register front end of a general-purpose I/O port with a parameterised number of lines. Lines are grouped eight to a bank. Each bank has an output-value register and a direction register. A simple 32-bit register bus reaches them, and the block turns their contents into per-line output values and output enables. Input pins are synchronised, and a read of a bank returns what each line is actually doing: the sampled pin for an input line and the driven value for an output line.

The bank registers do not sit at contiguous addresses. A 16-byte window is reserved for four interrupt-control registers, and every bank whose natural base would fall at or above that window moves up past it. The interrupt registers are a per-line enable, a per-line dual-edge mode, a per-line noise-filter enable and a shared filter cycle count. They leave the block as plain outputs, together with the synchronised levels of the upper lines that can raise interrupts. A separate conditioning stage consumes them.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Line n is controlled by bit n%8 of bank n/8. `gpio_out[n]` equals that bit of the bank's output-value register, and `gpio_oe[n]` is the inverse of that bit of the bank's direction register.
- R2: Bank b has its base at (b+1)*8. If that base is 0x90 or higher, 0x10 is added to it. The output-value register is at base+0 and the direction register is at base+4. Bank registers use data bits [7:0].
- R3: A direction bit of 1 makes the line an input, with its output enable low. After reset every direction bit is 1 and every output-value bit is 0.
- R4: A read of an output-value register returns, for each input line, the pin as seen through a two-stage synchroniser. A pin change becomes visible on the second rising edge after it. For each output line the read returns the register bit.
- R5: The output value drives `gpio_out` whatever the direction. Writing the value first and clearing the direction bit second therefore enables the pin already carrying the written value, with no cycle at the old value.
- R6: The interrupt enable is at 0x90, the dual-edge mode at 0x94 and the filter enable at 0x98, each with one bit per interrupt line. The filter cycle count is at 0x9C and occupies the low FLT_W bits. All four reset to 0, and each drives its own output port.
- R7: `irq_src[k]` is the synchronised level of line IRQ_FIRST+k and follows the pin after two rising edges.
- R8: Reads of unmapped addresses return 0, and writes to them change nothing. Unmapped addresses include 0x00–0x07, addresses past the last bank, and any address whose bits [1:0] are not zero.
- R9: Writes honour byte strobes: byte i of a register changes only when `bus_wstrb[i]` is 1. A bank register therefore changes only when strobe 0 is set.
- R10: In a last bank with fewer than eight lines, the missing bits read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wstrb | input | 4 | Byte enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gpio_in | input | NUM_LINES | Pin levels, asynchronous |
| gpio_out | output | NUM_LINES | Driven value per line |
| gpio_oe | output | NUM_LINES | Output enable per line |
| irq_src | output | NUM_IRQ | Synchronised levels of interrupt-capable lines |
| irq_en | output | NUM_IRQ | Interrupt enable per line |
| irq_mode | output | NUM_IRQ | Dual-edge mode per line |
| irq_flt_en | output | NUM_IRQ | Noise-filter enable per line |
| irq_flt_cyc | output | FLT_W | Shared filter cycle count |

## Verification
The bench builds the block with NUM_LINES=157, NUM_IRQ=32, IRQ_FIRST=120, FLT_W=8 and ADDR_W=9. That makes twenty banks, and the last one holds only five lines, so the partial-bank masking is exercised. With these values, banks 17 to 19 sit above the interrupt window, so the 0x10 skip is tested on several banks and not only at its edge. All 32 interrupt lines exist, so the full-width byte-strobe merges are reachable. The 9-bit address space also leaves room for accesses past the last bank.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
   localparam int BANK_W       = 8;
   localparam int HOLE_LO      = 'h90;
   localparam int HOLE_SPAN    = 'h10;
   localparam int OFS_IRQ_EN   = 'h90;
   localparam int OFS_IRQ_MODE = 'h94;
   localparam int OFS_IRQ_FLT  = 'h98;
   localparam int OFS_IRQ_CYC  = 'h9C;

   // byte base of bank idx, stepping over the interrupt register window
   function automatic int bank_base(input int idx);
      int b;
      b = (idx + 1) * BANK_W;
      if (b >= HOLE_LO) b = b + HOLE_SPAN;
      return b;
   endfunction

   // replace the strobed bytes of old_v with those of new_v
   function automatic logic [31:0] byte_merge(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  strb);
      logic [31:0] r;
      r = old_v;
      for (int i = 0; i < 4; i++)
         if (strb[i]) r[8*i +: 8] = new_v[8*i +: 8];
      return r;
   endfunction

   typedef enum logic [1:0] {
      IRQ_SEL_EN   = 2'((OFS_IRQ_EN   >> 2) & 3),
      IRQ_SEL_MODE = 2'((OFS_IRQ_MODE >> 2) & 3),
      IRQ_SEL_FLT  = 2'((OFS_IRQ_FLT  >> 2) & 3),
      IRQ_SEL_CYC  = 2'((OFS_IRQ_CYC  >> 2) & 3)
   } irq_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_a,
   output logic [W-1:0] pin_s
);
   logic [W-1:0] stage1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         pin_s  <= '0;
      end else begin
         stage1 <= pin_a;
         pin_s  <= stage1;
      end
   end
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int LINES = 8,
   parameter int BASE  = 8,
   parameter int AW    = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    word_addr,
   input  logic             wr_en,
   input  logic [LINES-1:0] wr_bits,
   input  logic [LINES-1:0] pin_s,
   output logic [LINES-1:0] data_q,
   output logic [LINES-1:0] dir_q,
   output logic [7:0]       rd_byte
);
   localparam logic [AW-2:0] PAIR_IDX = (AW-1)'(BASE / BANK_W);

   logic hit;
   logic sel_dir;

   assign hit     = (word_addr[AW-1:1] == PAIR_IDX);
   assign sel_dir = word_addr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '1;
      end else if (wr_en && hit) begin
         if (sel_dir) dir_q  <= wr_bits;
         else         data_q <= wr_bits;
      end
   end

   always_comb begin
      rd_byte = '0;
      if (hit) begin
         if (sel_dir) rd_byte[LINES-1:0] = dir_q;
         else         rd_byte[LINES-1:0] = (pin_s & dir_q) | (data_q & ~dir_q);
      end
   end
endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
   import gpio_bank_pkg::*;
#(
   parameter int NIRQ  = 32,
   parameter int FLT_W = 8,
   parameter int AW    = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    word_addr,
   input  logic             wr_en,
   input  logic [31:0]      wdata,
   input  logic [3:0]       wstrb,
   output logic [NIRQ-1:0]  en_q,
   output logic [NIRQ-1:0]  mode_q,
   output logic [NIRQ-1:0]  flt_q,
   output logic [FLT_W-1:0] cyc_q,
   output logic [31:0]      rd_word
);
   localparam logic [AW-3:0] WIN_IDX = (AW-2)'(HOLE_LO / HOLE_SPAN);

   logic     hit;
   irq_sel_e sel;

   assign hit = (word_addr[AW-1:2] == WIN_IDX);
   assign sel = irq_sel_e'(word_addr[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         mode_q <= '0;
         flt_q  <= '0;
         cyc_q  <= '0;
      end else if (wr_en && hit) begin
         case (sel)
            IRQ_SEL_EN:   en_q   <= NIRQ'(byte_merge(32'(en_q), wdata, wstrb));
            IRQ_SEL_MODE: mode_q <= NIRQ'(byte_merge(32'(mode_q), wdata, wstrb));
            IRQ_SEL_FLT:  flt_q  <= NIRQ'(byte_merge(32'(flt_q), wdata, wstrb));
            default:      cyc_q  <= FLT_W'(byte_merge(32'(cyc_q), wdata, wstrb));
         endcase
      end
   end

   always_comb begin
      rd_word = '0;
      if (hit) begin
         case (sel)
            IRQ_SEL_EN:   rd_word = 32'(en_q);
            IRQ_SEL_MODE: rd_word = 32'(mode_q);
            IRQ_SEL_FLT:  rd_word = 32'(flt_q);
            default:      rd_word = 32'(cyc_q);
         endcase
      end
   end
endmodule

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_LINES = 248,
   parameter int NUM_IRQ   = 32,
   parameter int IRQ_FIRST = 120,
   parameter int FLT_W     = 8,
   parameter int ADDR_W    = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [3:0]           bus_wstrb,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NUM_LINES-1:0] gpio_in,
   output logic [NUM_LINES-1:0] gpio_out,
   output logic [NUM_LINES-1:0] gpio_oe,
   output logic [NUM_IRQ-1:0]   irq_src,
   output logic [NUM_IRQ-1:0]   irq_en,
   output logic [NUM_IRQ-1:0]   irq_mode,
   output logic [NUM_IRQ-1:0]   irq_flt_en,
   output logic [FLT_W-1:0]     irq_flt_cyc
);
   localparam int NUM_BANKS = (NUM_LINES + BANK_W - 1) / BANK_W;
   localparam int LAST_BASE = bank_base(NUM_BANKS - 1);
   localparam int AW        = ADDR_W - 2;

   // elaboration-time parameter checks
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("NUM_LINES must be at least 1");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > 32) begin : g_bad_irq
      $error("NUM_IRQ must lie in 1..32");
   end
   if (IRQ_FIRST < 0 || IRQ_FIRST + NUM_IRQ > NUM_LINES) begin : g_bad_irq_map
      $error("interrupt lines must exist among the GPIO lines");
   end
   if (FLT_W < 1 || FLT_W > 32) begin : g_bad_flt
      $error("FLT_W must lie in 1..32");
   end
   if (LAST_BASE + BANK_W > (1 << ADDR_W) || ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too narrow for the bank map and interrupt window");
   end

   logic [AW-1:0]        word_addr;
   logic                 aligned;
   logic                 acc_wr;
   logic [NUM_LINES-1:0] pin_s;
   logic [7:0]           bank_rd [NUM_BANKS];
   logic [31:0]          irq_rd;

   assign word_addr = bus_addr[ADDR_W-1:2];
   assign aligned   = (bus_addr[1:0] == 2'b00);
   assign acc_wr    = bus_wr && aligned;

   gpio_pin_sync #(.W(NUM_LINES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_a (gpio_in),
      .pin_s (pin_s)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int LB = (NUM_LINES - BANK_W*b >= BANK_W) ? BANK_W
                                                           : NUM_LINES - BANK_W*b;
      logic [LB-1:0] dir_b;

      gpio_bank_regs #(.LINES(LB), .BASE(bank_base(b)), .AW(AW)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .word_addr (word_addr),
         .wr_en     (acc_wr && bus_wstrb[0]),
         .wr_bits   (bus_wdata[LB-1:0]),
         .pin_s     (pin_s[BANK_W*b +: LB]),
         .data_q    (gpio_out[BANK_W*b +: LB]),
         .dir_q     (dir_b),
         .rd_byte   (bank_rd[b])
      );

      assign gpio_oe[BANK_W*b +: LB] = ~dir_b;
   end

   gpio_irq_regs #(.NIRQ(NUM_IRQ), .FLT_W(FLT_W), .AW(AW)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_addr (word_addr),
      .wr_en     (acc_wr),
      .wdata     (bus_wdata),
      .wstrb     (bus_wstrb),
      .en_q      (irq_en),
      .mode_q    (irq_mode),
      .flt_q     (irq_flt_en),
      .cyc_q     (irq_flt_cyc),
      .rd_word   (irq_rd)
   );

   assign irq_src = pin_s[IRQ_FIRST +: NUM_IRQ];

   always_comb begin
      logic [31:0] acc;
      acc = irq_rd;
      for (int i = 0; i < NUM_BANKS; i++) acc = acc | {24'b0, bank_rd[i]};
      bus_rdata = aligned ? acc : 32'b0;
   end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_chk #(
   parameter int NUM_LINES = 248,
   parameter int NUM_IRQ   = 32,
   parameter int IRQ_FIRST = 120,
   parameter int FLT_W     = 8,
   parameter int ADDR_W    = 9
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_wr,
   input logic [3:0]           bus_wstrb,
   input logic [31:0]          bus_rdata,
   input logic [NUM_LINES-1:0] gpio_in,
   input logic [NUM_LINES-1:0] gpio_out,
   input logic [NUM_LINES-1:0] gpio_oe,
   input logic [NUM_IRQ-1:0]   irq_src,
   input logic [NUM_IRQ-1:0]   irq_en,
   input logic [NUM_IRQ-1:0]   irq_mode,
   input logic [NUM_IRQ-1:0]   irq_flt_en,
   input logic [FLT_W-1:0]     irq_flt_cyc
);
   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R3: direction, hence output enable, only moves on a bus write
   assert_oe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(gpio_oe));

   // R5: driven value only moves on a bus write
   assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(gpio_out));

   // R6: interrupt control outputs only move on a bus write
   assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable({irq_en, irq_mode, irq_flt_en, irq_flt_cyc}));

   // R9: a write with no byte strobes leaves every register as it was
   assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_wstrb == 4'b0000) |=>
         $stable({gpio_out, gpio_oe, irq_en, irq_mode, irq_flt_en, irq_flt_cyc}));

   // R8: the bottom eight bytes are unmapped
   assert_low_hole_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr < ADDR_W'(8)) |-> (bus_rdata == 32'b0));

   // R8: misaligned addresses read as zero
   assert_misalign_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'b0));

   // R7: interrupt source levels trail the pins by two edges
   assert_irq_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (irq_src == $past(gpio_in[IRQ_FIRST +: NUM_IRQ], 2)));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
   .NUM_LINES (NUM_LINES),
   .NUM_IRQ   (NUM_IRQ),
   .IRQ_FIRST (IRQ_FIRST),
   .FLT_W     (FLT_W),
   .ADDR_W    (ADDR_W)
) u_chk (.*);

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
   localparam int NL = 157;
   localparam int NI = 32;
   localparam int IF = 120;
   localparam int FW = 8;
   localparam int AWB = 9;

   typedef struct packed {
      logic        wr;
      logic [8:0]  addr;
      logic [31:0] data;
      logic [3:0]  strb;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 31;
   // rows: write (1) or read (0), address, data, strobes, expected read
   localparam vec_t VEC [NV] = '{
      '{1'b1, 9'h008, 32'h000000C5, 4'h1, 32'h0},        // bank0 value
      '{1'b0, 9'h008, 32'h0, 4'h0, 32'h0000005A},         // R4 all input: pins
      '{1'b1, 9'h00C, 32'h0000000F, 4'h1, 32'h0},        // bank0 dir: 7..4 out
      '{1'b0, 9'h008, 32'h0, 4'h0, 32'h000000CA},         // R4 R1 mixed read
      '{1'b0, 9'h00C, 32'h0, 4'h0, 32'h0000000F},         // R2 dir at base+4
      '{1'b1, 9'h088, 32'h000000C3, 4'h1, 32'h0},        // bank16 below window
      '{1'b1, 9'h08C, 32'h00000000, 4'h1, 32'h0},
      '{1'b0, 9'h088, 32'h0, 4'h0, 32'h000000C3},         // R2
      '{1'b1, 9'h0A0, 32'h0000003C, 4'h1, 32'h0},        // bank17 skipped past window
      '{1'b1, 9'h0A4, 32'h000000F0, 4'h1, 32'h0},
      '{1'b0, 9'h0A0, 32'h0, 4'h0, 32'h000000CC},         // R2 skip
      '{1'b0, 9'h0A4, 32'h0, 4'h0, 32'h000000F0},         // R2
      '{1'b1, 9'h090, 32'hDEADBEEF, 4'hF, 32'h0},
      '{1'b0, 9'h090, 32'h0, 4'h0, 32'hDEADBEEF},         // R6 enable
      '{1'b1, 9'h094, 32'h12345678, 4'h5, 32'h0},
      '{1'b0, 9'h094, 32'h0, 4'h0, 32'h00340078},         // R9 bytes 0 and 2
      '{1'b1, 9'h098, 32'hFFFFFFFF, 4'h8, 32'h0},
      '{1'b0, 9'h098, 32'h0, 4'h0, 32'hFF000000},         // R9 byte 3
      '{1'b1, 9'h09C, 32'h000001FF, 4'h1, 32'h0},
      '{1'b0, 9'h09C, 32'h0, 4'h0, 32'h000000FF},         // R6 cycle count width
      '{1'b1, 9'h000, 32'h000000FF, 4'hF, 32'h0},
      '{1'b0, 9'h000, 32'h0, 4'h0, 32'h0},                // R8 low hole
      '{1'b0, 9'h0B8, 32'h0, 4'h0, 32'h0},                // R8 past last bank
      '{1'b0, 9'h1F0, 32'h0, 4'h0, 32'h0},                // R8
      '{1'b0, 9'h089, 32'h0, 4'h0, 32'h0},                // R8 misaligned
      '{1'b1, 9'h0B0, 32'h000000FF, 4'h1, 32'h0},        // last bank, 5 lines
      '{1'b1, 9'h0B4, 32'h00000000, 4'h1, 32'h0},
      '{1'b0, 9'h0B0, 32'h0, 4'h0, 32'h0000001F},         // R10
      '{1'b1, 9'h0B4, 32'h000000FF, 4'h1, 32'h0},
      '{1'b0, 9'h0B4, 32'h0, 4'h0, 32'h0000001F},         // R10
      '{1'b1, 9'h0B4, 32'h00000000, 4'h1, 32'h0}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AWB-1:0]  bus_addr = '0;
   logic            bus_wr = 1'b0;
   logic [3:0]      bus_wstrb = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NL-1:0]   pins = '0;
   logic [NL-1:0]   gpio_out, gpio_oe;
   logic [NI-1:0]   irq_src, irq_en, irq_mode, irq_flt_en;
   logic [FW-1:0]   irq_flt_cyc;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   gpio_bank_ctrl #(.NUM_LINES(NL), .NUM_IRQ(NI), .IRQ_FIRST(IF),
                    .FLT_W(FW), .ADDR_W(AWB)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .gpio_in(pins), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
      .irq_src(irq_src), .irq_en(irq_en), .irq_mode(irq_mode),
      .irq_flt_en(irq_flt_en), .irq_flt_cyc(irq_flt_cyc));

   function automatic logic [7:0] pin_pat(input int b);
      return 8'((b * 37 + 90) & 255);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [8:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wstrb = '0;
      #1;
   endtask

   task automatic do_read(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      #(8 * 200000);
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0]   rd;
      logic [NL-1:0] snap_out, snap_oe;
      logic [NI-1:0] old_src;

      for (int n = 0; n < NL; n++) pins[n] = pin_pat(n / 8)[n % 8];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // reset state
      #1;
      chk("R3 reset oe low", 32'(gpio_oe == '0), 32'd1);
      chk("R3 reset out zero", 32'(gpio_out == '0), 32'd1);
      chk("R6 reset irq regs", {irq_en | irq_mode | irq_flt_en}, 32'h0);
      chk("R6 reset flt cyc", 32'(irq_flt_cyc), 32'h0);
      do_read(9'h00C, rd); chk("R3 reset dir bank0", rd, 32'hFF);
      do_read(9'h0B4, rd); chk("R10 reset dir last bank", rd, 32'h1F);
      do_read(9'h010, rd); chk("R4 reset read bank1 pins", rd, 32'(pin_pat(1)));

      // table walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) do_write(VEC[i].addr, VEC[i].data, VEC[i].strb);
         else begin
            do_read(VEC[i].addr, rd);
            chk($sformatf("table row %0d", i), rd, VEC[i].exp);
         end
      end

      // R1 per-line mapping at the pins
      #1;
      chk("R1 bank0 out", 32'(gpio_out[7:0]), 32'hC5);
      chk("R1 bank0 oe", 32'(gpio_oe[7:0]), 32'hF0);
      chk("R1 bank16 out", 32'(gpio_out[135:128]), 32'hC3);
      chk("R1 bank16 oe", 32'(gpio_oe[135:128]), 32'hFF);
      chk("R1 bank17 out", 32'(gpio_out[143:136]), 32'h3C);
      chk("R1 bank17 oe", 32'(gpio_oe[143:136]), 32'h0F);
      chk("R10 last bank out", 32'(gpio_out[156:152]), 32'h1F);
      chk("R10 last bank oe", 32'(gpio_oe[156:152]), 32'h1F);

      // R6 interrupt control ports
      chk("R6 irq_en port", irq_en, 32'hDEADBEEF);
      chk("R6 irq_mode port", irq_mode, 32'h00340078);
      chk("R6 irq_flt_en port", irq_flt_en, 32'hFF000000);
      chk("R6 irq_flt_cyc port", 32'(irq_flt_cyc), 32'hFF);

      // R4 synchroniser latency on an input bank
      @(negedge clk);
      pins[15:8] = 8'h81;
      bus_addr = 9'h010;
      @(negedge clk); #1;
      chk("R4 one edge still old", bus_rdata, 32'(pin_pat(1)));
      @(negedge clk); #1;
      chk("R4 two edges new", bus_rdata, 32'h81);

      // R7 interrupt source follows pins after two edges
      @(negedge clk);
      old_src = pins[IF +: NI];
      pins[IF +: NI] = 32'h1234ABCD;
      @(negedge clk); #1;
      chk("R7 one edge old", irq_src, old_src);
      @(negedge clk); #1;
      chk("R7 two edges new", irq_src, 32'h1234ABCD);

      // R5 value first, then direction: no glitch
      do_write(9'h018, 32'hA5, 4'h1);
      chk("R5 value while input", 32'(gpio_out[23:16]), 32'hA5);
      chk("R5 still not driven", 32'(gpio_oe[23:16]), 32'h00);
      do_write(9'h01C, 32'h00, 4'h1);
      chk("R5 enabled with value", {gpio_out[23:16], gpio_oe[23:16]}, 32'hA5FF);

      // R8 writes to unmapped or misaligned addresses are ignored
      snap_out = gpio_out; snap_oe = gpio_oe;
      do_write(9'h1F8, 32'hFFFFFFFF, 4'hF);
      do_write(9'h00D, 32'h00000000, 4'hF);
      do_write(9'h0B9, 32'h00000000, 4'hF);
      chk("R8 out unchanged", 32'(gpio_out == snap_out), 32'd1);
      chk("R8 oe unchanged", 32'(gpio_oe == snap_oe), 32'd1);
      do_read(9'h00C, rd); chk("R8 dir bank0 kept", rd, 32'h0F);

      // R9 bank write without strobe 0 does nothing
      do_write(9'h008, 32'h00000000, 4'hE);
      chk("R9 bank0 out kept", 32'(gpio_out[7:0]), 32'hC5);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule